// File: doc/BRIEF.md
# Built-in Test Pattern Source for a Two-Channel Image Front End

This block sits between the converter outputs and the output multiplexer of a line-sensor front end. While test mode is off, each channel's converter code is registered on every valid pixel and passed straight through. While test mode is on, the converter data is ignored and every channel carries the same synthetic code. The code comes from one of two generators, chosen by a pattern-select input.

The stripe generator outputs runs of equal length. The runs alternate between the programmed black level and that level raised by 128. The gradation generator is a ramp that starts at 1, holds each code for a fixed number of pixels, then steps up by one. A two-bit interval code sets the run length for both patterns. Both generators restart at every line-start strobe and on the cycle where test mode is switched on. Because the patterns are built only from the pixel strobe, they appear whether or not any signal reaches the converters.

Top module: `tpg_top`

## Requirements
- R1: After reset every output channel reads 0.
- R2: With `test_en` low, a cycle with `pix_valid` high makes each channel's output equal that channel's `din` slice from the same cycle, visible after the next clock edge.
- R3: Outputs change only after cycles with `pix_valid` high. Pattern counters advance only on such cycles, so idle gaps neither alter the output nor lengthen a run.
- R4: With `test_en` high and `pat_sel` = 1 (stripe), pixels alternate in runs of 8, 16, 32 or 64 for `ival_code` 0, 1, 2, 3. The first run of a line is the black level, equal to 2 × `black_code`. The next run is the black level + 128, and so on.
- R5: Both stripe levels saturate at the all-ones output code.
- R6: With `test_en` high and `pat_sel` = 0 (gradation), the first pixel of a line is 1. Each code is held for 2, 4, 8 or 16 pixels for `ival_code` 0, 1, 2, 3, then rises by 1.
- R7: The gradation code wraps from the all-ones value back to 1 and never outputs 0.
- R8: A `line_start` pulse restarts both patterns. A pixel in the same cycle as the pulse is the first pixel of the new line.
- R9: The first cycle with `test_en` high restarts both patterns in the same way as `line_start`.
- R10: In test mode all channels carry identical codes, and `din` has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | High in cycles that carry a pixel |
| line_start | input | 1 | One-cycle strobe at the start of a line |
| test_en | input | 1 | 1 = output test patterns, 0 = pass converter data |
| pat_sel | input | 1 | 0 = gradation ramp, 1 = stripes |
| ival_code | input | 2 | Run length / hold interval code |
| black_code | input | BLK_W | Black level in 2-LSB units |
| din | input | NCH*OUT_W | Converter codes, channel 0 in the low bits |
| dout | output | NCH*OUT_W | Output codes to the multiplexer, channel 0 in the low bits |

## Verification
The bench builds the block with two 10-bit channels and a 9-bit black-level field, instead of the default 12-bit and 8-bit widths. With these values the ramp wraps after 1023 codes, which takes about two thousand pixels at the shortest interval. A black code of 511 also pushes the stripe high level past the output range, so the saturation path is reachable. The default widths never reach that path.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    typedef enum logic {
        PAT_RAMP   = 1'b0,
        PAT_STRIPE = 1'b1
    } pat_e;

    localparam int STRIPE_LIFT = 128;
endpackage

// File: rtl/tpg_run_timer.sv
module tpg_run_timer #(
    parameter int S_LOG2 = 3,
    parameter int R_LOG2 = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       adv,
    input  logic       pat_sel,
    input  logic [1:0] ival_code,
    output logic       run_end
);
    import tpg_pkg::*;

    localparam int MAXLOG = ((S_LOG2 > R_LOG2) ? S_LOG2 : R_LOG2) + 3;
    localparam int CNT_W  = MAXLOG + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic [CNT_W-1:0] len_m1;
    logic [CNT_W-1:0] cur;
    logic             last;

    always_comb begin
        if (pat_e'(pat_sel) == PAT_STRIPE)
            len_m1 = (CNT_W'(1) << (CNT_W'(S_LOG2) + CNT_W'(ival_code))) - CNT_W'(1);
        else
            len_m1 = (CNT_W'(1) << (CNT_W'(R_LOG2) + CNT_W'(ival_code))) - CNT_W'(1);
        cur     = clear ? '0 : st_q.cnt;
        last    = (cur >= len_m1);
        run_end = adv && last;
        st_d    = st_q;
        if (adv)
            st_d.cnt = last ? '0 : cur + CNT_W'(1);
        else
            st_d.cnt = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tpg_pattern_core.sv
module tpg_pattern_core #(
    parameter int OUT_W = 12,
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             adv,
    input  logic             run_end,
    input  logic             pat_sel,
    input  logic [BLK_W-1:0] black_code,
    output logic [OUT_W-1:0] pat_val
);
    import tpg_pkg::*;

    localparam int SUM_W = ((OUT_W > BLK_W + 1) ? OUT_W : BLK_W + 1) + 2;
    localparam logic [OUT_W-1:0] CODE_MAX = {OUT_W{1'b1}};
    localparam logic [OUT_W-1:0] CODE_ONE = OUT_W'(1);

    typedef struct packed {
        logic             phase;
        logic [OUT_W-1:0] code;
    } core_st_t;

    core_st_t st_d, st_q;
    logic             cur_phase;
    logic [OUT_W-1:0] cur_code;
    logic [SUM_W-1:0] lo_sum, hi_sum;
    logic [OUT_W-1:0] lo_lvl, hi_lvl;

    always_comb begin
        lo_sum = SUM_W'({black_code, 1'b0});
        hi_sum = lo_sum + SUM_W'(STRIPE_LIFT);
        lo_lvl = (lo_sum > SUM_W'(CODE_MAX)) ? CODE_MAX : lo_sum[OUT_W-1:0];
        hi_lvl = (hi_sum > SUM_W'(CODE_MAX)) ? CODE_MAX : hi_sum[OUT_W-1:0];
    end

    always_comb begin
        cur_phase = clear ? 1'b0 : st_q.phase;
        cur_code  = clear ? CODE_ONE : st_q.code;
        if (pat_e'(pat_sel) == PAT_STRIPE)
            pat_val = cur_phase ? hi_lvl : lo_lvl;
        else
            pat_val = cur_code;
        st_d.phase = cur_phase;
        st_d.code  = cur_code;
        if (adv && run_end) begin
            st_d.phase = ~cur_phase;
            st_d.code  = (cur_code == CODE_MAX) ? CODE_ONE : cur_code + CODE_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= 1'b0;
            st_q.code  <= CODE_ONE;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tpg_top.sv
module tpg_top #(
    parameter int NCH    = 2,
    parameter int OUT_W  = 12,
    parameter int BLK_W  = 8,
    parameter int S_LOG2 = 3,
    parameter int R_LOG2 = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pix_valid,
    input  logic                 line_start,
    input  logic                 test_en,
    input  logic                 pat_sel,
    input  logic [1:0]           ival_code,
    input  logic [BLK_W-1:0]     black_code,
    input  logic [NCH*OUT_W-1:0] din,
    output logic [NCH*OUT_W-1:0] dout
);
    localparam int BUS_W = NCH * OUT_W;

    typedef struct packed {
        logic             test_q;
        logic [BUS_W-1:0] data;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             clear;
    logic             run_end;
    logic [OUT_W-1:0] pat_val;
    logic [BUS_W-1:0] out_nxt;

    assign clear = line_start || (test_en && !st_q.test_q);

    tpg_run_timer #(.S_LOG2(S_LOG2), .R_LOG2(R_LOG2)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .adv       (pix_valid),
        .pat_sel   (pat_sel),
        .ival_code (ival_code),
        .run_end   (run_end)
    );

    tpg_pattern_core #(.OUT_W(OUT_W), .BLK_W(BLK_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .adv        (pix_valid),
        .run_end    (run_end),
        .pat_sel    (pat_sel),
        .black_code (black_code),
        .pat_val    (pat_val)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        always_comb begin
            out_nxt[ch*OUT_W +: OUT_W] = test_en ? pat_val : din[ch*OUT_W +: OUT_W];
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.test_q = test_en;
        if (pix_valid)
            st_d.data = out_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.data;
endmodule

// File: rtl/tpg_chk.sv
module tpg_chk #(
    parameter int NCH   = 2,
    parameter int OUT_W = 12,
    parameter int BLK_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pix_valid,
    input logic                 line_start,
    input logic                 test_en,
    input logic                 pat_sel,
    input logic [BLK_W-1:0]     black_code,
    input logic [NCH*OUT_W-1:0] din,
    input logic [NCH*OUT_W-1:0] dout
);
    localparam int W2 = ((OUT_W > BLK_W + 1) ? OUT_W : BLK_W + 1) + 1;
    localparam logic [W2-1:0] MAXV = W2'({OUT_W{1'b1}});

    logic [OUT_W-1:0] ch0;
    logic             all_eq;
    logic [W2-1:0]    blk2;
    logic [OUT_W-1:0] lo_exp;

    always_comb begin
        ch0    = dout[OUT_W-1:0];
        all_eq = 1'b1;
        for (int c = 1; c < NCH; c++)
            if (dout[c*OUT_W +: OUT_W] != ch0) all_eq = 1'b0;
        blk2   = W2'({black_code, 1'b0});
        lo_exp = (blk2 > MAXV) ? MAXV[OUT_W-1:0] : blk2[OUT_W-1:0];
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> $stable(dout));

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !test_en) |=> dout == $past(din));

    p_same_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && test_en) |=> all_eq);

    p_ramp_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && test_en && !pat_sel) |=> ch0 != '0);

    p_stripe_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && test_en && pat_sel) |=> ch0 >= $past(lo_exp));

    p_line_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && line_start && test_en && !pat_sel) |=> ch0 == OUT_W'(1));
endmodule

bind tpg_top tpg_chk #(.NCH(NCH), .OUT_W(OUT_W), .BLK_W(BLK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .line_start (line_start),
    .test_en    (test_en),
    .pat_sel    (pat_sel),
    .black_code (black_code),
    .din        (din),
    .dout       (dout)
);

// File: tb/tb_tpg_top.sv
module tb_tpg_top;
    localparam int NCH   = 2;
    localparam int OUT_W = 10;
    localparam int BLK_W = 9;
    localparam int MAXV  = (1 << OUT_W) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 pix_valid = 1'b0;
    logic                 line_start = 1'b0;
    logic                 test_en = 1'b0;
    logic                 pat_sel = 1'b0;
    logic [1:0]           ival_code = 2'd0;
    logic [BLK_W-1:0]     black_code = '0;
    logic [NCH*OUT_W-1:0] din = '0;
    logic [NCH*OUT_W-1:0] dout;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tpg_top #(.NCH(NCH), .OUT_W(OUT_W), .BLK_W(BLK_W)) dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .line_start(line_start),
        .test_en(test_en), .pat_sel(pat_sel), .ival_code(ival_code),
        .black_code(black_code), .din(din), .dout(dout)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // one cycle: drive at negedge, sample shortly after the rising edge
    task automatic cyc(input bit v, input bit ls);
        @(negedge clk);
        pix_valid  = v;
        line_start = ls;
        din        = {OUT_W'($urandom), OUT_W'($urandom)};
        @(posedge clk);
        #2;
        pix_valid  = 1'b0;
        line_start = 1'b0;
    endtask

    function automatic int stripe_exp(input int i, input int code, input int blk);
        int len = 8 << code;
        int lo  = (2 * blk > MAXV) ? MAXV : 2 * blk;
        int hi  = (2 * blk + 128 > MAXV) ? MAXV : 2 * blk + 128;
        return ((i / len) % 2) ? hi : lo;
    endfunction

    function automatic int ramp_exp(input int i, input int code);
        return ((i / (2 << code)) % MAXV) + 1;
    endfunction

    task automatic chk_both(input string req, input int exp);
        chk({req, " ch0"}, int'(dout[OUT_W-1:0]), exp);
        chk({req, " ch1"}, int'(dout[2*OUT_W-1:OUT_W]), exp);
    endtask

    task automatic t_reset;
        chk_both("R1", 0);
    endtask

    task automatic t_pass;
        logic [NCH*OUT_W-1:0] snap;
        test_en = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            pix_valid = 1'b1;
            din = {OUT_W'(100 + k * 7), OUT_W'(900 - k * 3)};
            @(posedge clk);
            #2;
            pix_valid = 1'b0;
            chk("R2 ch0", int'(dout[OUT_W-1:0]), 900 - k * 3);
            chk("R2 ch1", int'(dout[2*OUT_W-1:OUT_W]), 100 + k * 7);
        end
        snap = dout;
        for (int k = 0; k < 3; k++) begin
            cyc(1'b0, 1'b0);
            chk("R3 hold", int'(dout), int'(snap));
        end
    endtask

    task automatic t_stripe(input int code, input int blk, input string req);
        test_en = 1'b1; pat_sel = 1'b1; ival_code = 2'(code); black_code = BLK_W'(blk);
        cyc(1'b0, 1'b1);
        for (int i = 0; i < 3 * (8 << code); i++) begin
            cyc(1'b1, 1'b0);
            chk_both(req, stripe_exp(i, code, blk));  // R10 both channels, din ignored
        end
    endtask

    task automatic t_ramp(input int code);
        test_en = 1'b1; pat_sel = 1'b0; ival_code = 2'(code);
        cyc(1'b0, 1'b1);
        for (int i = 0; i < 5 * (2 << code); i++) begin
            cyc(1'b1, 1'b0);
            chk_both("R6", ramp_exp(i, code));
        end
    endtask

    task automatic t_gaps;
        int i = 0;
        test_en = 1'b1; pat_sel = 1'b0; ival_code = 2'd1;
        cyc(1'b0, 1'b1);
        for (int k = 0; k < 24; k++) begin
            bit v = (k % 3) != 1;
            cyc(v, 1'b0);
            if (v) i++;
            chk("R3 gaps", int'(dout[OUT_W-1:0]), (i == 0) ? 0 : ramp_exp(i - 1, 1));
        end
    endtask

    task automatic t_wrap;
        test_en = 1'b1; pat_sel = 1'b0; ival_code = 2'd0;
        cyc(1'b0, 1'b1);
        for (int i = 0; i < 2 * MAXV + 6; i++) begin
            cyc(1'b1, 1'b0);
            if (i >= 2 * MAXV - 4) chk_both("R7", ramp_exp(i, 0));
        end
    endtask

    task automatic t_line_mid;
        test_en = 1'b1; pat_sel = 1'b0; ival_code = 2'd0;
        cyc(1'b0, 1'b1);
        for (int i = 0; i < 7; i++) cyc(1'b1, 1'b0);
        chk_both("R8 pre", 4);
        cyc(1'b1, 1'b1);
        chk_both("R8 first", 1);
        for (int i = 1; i < 6; i++) begin
            cyc(1'b1, 1'b0);
            chk_both("R8 cont", ramp_exp(i, 0));
        end
    endtask

    task automatic t_entry;
        test_en = 1'b1; pat_sel = 1'b1; ival_code = 2'd0; black_code = BLK_W'(40);
        cyc(1'b0, 1'b1);
        for (int i = 0; i < 11; i++) cyc(1'b1, 1'b0);
        test_en = 1'b0;
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0);
        test_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            cyc(1'b1, 1'b0);
            chk_both("R9", stripe_exp(i, 0, 40));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_pass();
        t_stripe(0, 80, "R4");
        t_stripe(2, 17, "R4");
        t_stripe(3, 200, "R4");
        t_stripe(0, 511, "R5");
        t_stripe(1, 460, "R5");
        t_ramp(0);
        t_ramp(1);
        t_ramp(3);
        t_gaps();
        t_line_mid();
        t_entry();
        t_wrap();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule